// File: doc/BRIEF.md
# PPS Phase Error Accumulator

This block digitizes the phase offset between a once-per-second timing pulse from a satellite receiver and a divided-down local oscillator. A feedback divider counts oscillator ticks and produces one event every `DIV_N` ticks. When the block is armed, the first reference pulse restarts that divider, so the divider and the reference begin one period in step. The block then waits for the next divider event and the next reference event. The span between them is a window. A saturating signed counter measures the window, and the sign of the count records which of the two events came first.

The whole block runs on one fast system clock. The oscillator enters as a one-cycle tick strobe that is synchronous to this clock. A select input chooses the counting rate. In fine mode the counter advances on every system clock. In coarse mode it advances only on oscillator ticks. A host polls an active-low ready flag and reads the signed result in two halves over a narrow bus. It then acknowledges the read. The acknowledge clears the result and re-arms the block, so in normal use one result is produced every two reference periods. An accumulate mode sums several consecutive windows without restarting the divider, which gives multi-period averaging.

Top module: `pps_phase_meter`

## Requirements
- R1: The divider produces one event on every `DIV_N`-th oscillator tick after a restart, where the restart counts as position zero. Oscillator ticks are the cycles with `osc_tick` high.
- R2: `ref_pps` passes through a two-flop synchronizer and then a rising-edge detector. A rising edge driven between clock edges k and k+1 acts at clock edge k+3. While the block is armed, that edge restarts the divider.
- R3: After arming, the result is the signed number of counting cycles strictly after the earlier event, up to and including the cycle of the later event. The result is positive when the reference leads and negative (two's complement, `MAG_W`+1 bits) when the divider leads. It is zero when both events act on the same edge.
- R4: With `fine_sel`=1 the count advances on every clock. With `fine_sel`=0 it advances only on cycles with `osc_tick` high.
- R5: The result saturates at +(2^`MAG_W`−1) and −(2^`MAG_W`−1), which is ±511 by default. `ovf` goes high when a count step is blocked by the limit.
- R6: `rdy_n` falls at the clock edge where the closing event acts. Until an acknowledge arrives, `rdy_n`, the result and `ovf` hold, and further reference pulses have no effect.
- R7: The `MAG_W`+1 bit result is sign-extended to an even width and split into two halves. With `rd_hi`=1, `rd_data` shows the upper half; with `rd_hi`=0 it shows the lower half. The bus is combinational.
- R8: With `rdy_n` low, `rd_ack` high at a clock edge sets `rdy_n` high, clears the result and `ovf`, and re-arms the block to wait for the next reference pulse.
- R9: With `accum_en`=1, `ACC_WIN` windows are summed into one saturating result without restarting the divider. `rdy_n` falls only when the last window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counting and control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle strobe per local oscillator period |
| ref_pps | input | 1 | Asynchronous once-per-second reference pulse |
| fine_sel | input | 1 | 1: count every clock; 0: count oscillator ticks |
| accum_en | input | 1 | 1: sum `ACC_WIN` windows before ready |
| rd_hi | input | 1 | Half select for the readout bus |
| rd_ack | input | 1 | Host acknowledge of a read |
| rd_data | output | (MAG_W+2)/2 | Selected half of the signed result |
| rdy_n | output | 1 | Low while a result waits for the host |
| ovf | output | 1 | Result hit the saturation limit |

## Verification
A reference edge driven just after clock edge k becomes an event at edge k+3. The restarted divider fires `DIV_N` ticks after the restart edge. So the bench can compute from its own drive schedule the edge at which the closing event acts. It samples `rdy_n` on the falling edge just before that edge, expecting high, and on the falling edge just after it, expecting low. The result and `ovf` are then read through the half-select bus. The acknowledge is checked one clock later. For the coarse test, the bench aligns a tick pattern that alternates every cycle to the reference drive, so that the expected tick count inside the window is known exactly.

// File: rtl/pps_meter_pkg.sv
package pps_meter_pkg;
  typedef enum logic [1:0] {
    ST_SYNC = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPEN = 2'd2,
    ST_DONE = 2'd3
  } meas_state_t;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;

  // R2: a detected edge lasts exactly one cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fb_divider.sv
module fb_divider #(
  parameter int DIV_N = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic wrap_o
);
  localparam int DW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV_N - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign wrap_o = tick_i && !restart_i && (cnt_q == LAST);

  // R1: the position never leaves 0..DIV_N-1
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R1: no event without an oscillator tick
  p_wrap_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> tick_i);
endmodule

// File: rtl/phase_window_acc.sv
module phase_window_acc
  import pps_meter_pkg::*;
#(
  parameter int MAG_W   = 9,
  parameter int ACC_WIN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_evt_i,
  input  logic                     div_evt_i,
  input  logic                     cnt_en_i,
  input  logic                     accum_i,
  input  logic                     ack_i,
  output logic                     restart_o,
  output logic signed [MAG_W:0]    result_o,
  output logic                     ovf_o,
  output logic                     rdy_n_o
);
  localparam int RES_W = MAG_W + 1;
  localparam int WCW   = (ACC_WIN > 1) ? $clog2(ACC_WIN) : 1;
  localparam logic signed [RES_W-1:0] LIM_P = RES_W'((2 ** MAG_W) - 1);
  localparam logic signed [RES_W-1:0] LIM_N = -LIM_P;
  localparam logic signed [RES_W-1:0] ONE   = RES_W'(1);
  localparam logic [WCW-1:0] WIN_LAST = WCW'(ACC_WIN - 1);

  // Returns {limit_hit, next_value}; a step toward a limit already reached is blocked.
  function automatic logic [RES_W:0] sat_step(input logic signed [RES_W-1:0] a,
                                              input logic down);
    if (down) begin
      if (a == LIM_N) return {1'b1, a};
      return {1'b0, a - ONE};
    end
    if (a == LIM_P) return {1'b1, a};
    return {1'b0, a + ONE};
  endfunction

  meas_state_t state_q;
  logic signed [RES_W-1:0] acc_q;
  logic ovf_q, div_lead_q;
  logic [WCW-1:0] win_q;

  logic close_evt, last_win, any_evt, tie_evt;
  logic [RES_W:0] step;

  always_comb begin
    close_evt = div_lead_q ? ref_evt_i : div_evt_i;
    last_win  = !accum_i || (win_q == WIN_LAST);
    any_evt   = ref_evt_i || div_evt_i;
    tie_evt   = ref_evt_i && div_evt_i;
    step      = sat_step(acc_q, div_lead_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_SYNC;
      acc_q      <= '0;
      ovf_q      <= 1'b0;
      div_lead_q <= 1'b0;
      win_q      <= '0;
    end else begin
      unique case (state_q)
        ST_SYNC: if (ref_evt_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (tie_evt) begin
            if (last_win) state_q <= ST_DONE;
            else win_q <= win_q + 1'b1;
          end else if (any_evt) begin
            state_q    <= ST_OPEN;
            div_lead_q <= div_evt_i;
          end
        end
        ST_OPEN: begin
          if (cnt_en_i) begin
            acc_q <= step[RES_W-1:0];
            if (step[RES_W]) ovf_q <= 1'b1;
          end
          if (close_evt) begin
            if (last_win) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_WAIT;
              win_q   <= win_q + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (ack_i) begin
            state_q <= ST_SYNC;
            acc_q   <= '0;
            ovf_q   <= 1'b0;
            win_q   <= '0;
          end
        end
        default: state_q <= ST_SYNC;
      endcase
    end
  end

  assign restart_o = (state_q == ST_SYNC) && ref_evt_i;
  assign result_o  = acc_q;
  assign ovf_o     = ovf_q;
  assign rdy_n_o   = (state_q != ST_DONE);

  // R5: the result never leaves the symmetric range
  p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q >= LIM_N) && (acc_q <= LIM_P));
  // R5: the flag rises only with the result pinned at a limit
  p_ovf_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (acc_q == LIM_P || acc_q == LIM_N));
  // R4: no counting step on a disabled cycle
  p_count_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN && !cnt_en_i) |=> $stable(acc_q));
  // R6: a pending result holds until acknowledged
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !ack_i) |=> (state_q == ST_DONE && $stable(acc_q) && $stable(ovf_q)));
  // R8: acknowledge clears and re-arms
  p_ack_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && ack_i) |=> (rdy_n_o && acc_q == '0 && !ovf_q && state_q == ST_SYNC));
  // R2: arming edge moves on to waiting for the window
  p_sync_to_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (state_q == ST_WAIT));
endmodule

// File: rtl/pps_phase_meter.sv
module pps_phase_meter #(
  parameter int DIV_N   = 10_000_000,
  parameter int MAG_W   = 9,
  parameter int ACC_WIN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     osc_tick,
  input  logic                     ref_pps,
  input  logic                     fine_sel,
  input  logic                     accum_en,
  input  logic                     rd_hi,
  input  logic                     rd_ack,
  output logic [(MAG_W+2)/2-1:0]   rd_data,
  output logic                     rdy_n,
  output logic                     ovf
);
  localparam int RES_W  = MAG_W + 1;
  localparam int HALF_W = (RES_W + 1) / 2;

  logic ref_evt, div_evt, restart, cnt_en;
  logic signed [RES_W-1:0] result;
  logic signed [2*HALF_W-1:0] res_ext;

  pps_edge_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ref_pps),
    .rise_o (ref_evt)
  );

  fb_divider #(.DIV_N(DIV_N)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (osc_tick),
    .restart_i (restart),
    .wrap_o    (div_evt)
  );

  assign cnt_en = fine_sel | osc_tick;

  phase_window_acc #(.MAG_W(MAG_W), .ACC_WIN(ACC_WIN)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_evt_i (ref_evt),
    .div_evt_i (div_evt),
    .cnt_en_i  (cnt_en),
    .accum_i   (accum_en),
    .ack_i     (rd_ack),
    .restart_o (restart),
    .result_o  (result),
    .ovf_o     (ovf),
    .rdy_n_o   (rdy_n)
  );

  assign res_ext = (2*HALF_W)'(result);
  assign rd_data = rd_hi ? res_ext[2*HALF_W-1:HALF_W] : res_ext[HALF_W-1:0];

  // R3: a result can only become ready after an event acted
  p_ready_from_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(ref_evt || div_evt));
endmodule

// File: tb/pps_phase_meter_tb_top.sv
module pps_phase_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 600;
  localparam int MW   = 9;
  localparam int AW   = 3;
  localparam int HW   = (MW + 2) / 2;
  localparam int LIM  = (2 ** MW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_fixed = 1'b1;
  logic alt_mode = 1'b0;
  logic ph = 1'b0;
  logic osc_tick;
  logic ref_pps = 1'b0, fine_sel = 1'b1, accum_en = 1'b0;
  logic rd_hi = 1'b0, rd_ack = 1'b0;
  logic [HW-1:0] rd_data;
  logic rdy_n, ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) ph <= ~ph;
  assign osc_tick = alt_mode ? ph : osc_fixed;

  pps_phase_meter #(.DIV_N(N), .MAG_W(MW), .ACC_WIN(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ref_pps(ref_pps),
    .fine_sel(fine_sel), .accum_en(accum_en), .rd_hi(rd_hi), .rd_ack(rd_ack),
    .rd_data(rd_data), .rdy_n(rdy_n), .ovf(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Raise the reference now, hold two cycles, return gap falling edges after the rise.
  task automatic pps_pulse(input int gap);
    ref_pps = 1'b1;
    repeat (2) @(negedge clk);
    ref_pps = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic read_ack(input string req, input int expv, input int exp_ovf);
    logic [HW-1:0] hi, lo;
    logic signed [2*HW-1:0] val;
    rd_hi = 1'b1; #1; hi = rd_data;
    rd_hi = 1'b0; #1; lo = rd_data;
    val = {hi, lo};
    chk({req, " result (R7 halves)"}, int'(val), expv);
    chk({req, " ovf"}, int'(ovf), exp_ovf);
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
    chk("R8 rdy_n after ack", int'(rdy_n), 1);
    chk("R8 ovf after ack", int'(ovf), 0);
    rd_hi = 1'b1; #1; hi = rd_data;
    rd_hi = 1'b0; #1; lo = rd_data;
    chk("R8 result cleared", int'({hi, lo}), 0);
  endtask

  // One armed measurement with the second reference rise delta cycles after the first.
  task automatic meas(input string req, input int delta, input int expv, input int exp_ovf);
    pps_pulse(delta);
    pps_pulse(2);
    if (delta < N) begin
      @(negedge clk);
      repeat (N - delta - 1) @(negedge clk);
    end
    chk({req, " R6 rdy_n before closing edge"}, int'(rdy_n), 1);
    @(negedge clk);
    chk({req, " R6 rdy_n at closing edge"}, int'(rdy_n), 0);
    read_ack(req, expv, exp_ovf);
  endtask

  task automatic t_reset;
    chk("R6 reset rdy_n", int'(rdy_n), 1);
    chk("R5 reset ovf", int'(ovf), 0);
    rd_hi = 1'b1; #1; chk("R7 reset hi", int'(rd_data), 0);
    rd_hi = 1'b0; #1; chk("R7 reset lo", int'(rd_data), 0);
  endtask

  task automatic t_ref_leads;   // R3 positive, R1 divider timing
    meas("R3 ref leads", N - 37, 37, 0);
  endtask

  task automatic t_div_leads_ignore;  // R3 negative, R6 extra pulses ignored, R7 halves
    logic [HW-1:0] hi, lo;
    pps_pulse(N + 23);
    pps_pulse(2);
    chk("R3 div leads rdy_n before", int'(rdy_n), 1);
    @(negedge clk);
    chk("R3 div leads rdy_n at close", int'(rdy_n), 0);
    pps_pulse(40);
    pps_pulse(30);
    chk("R6 rdy_n held", int'(rdy_n), 0);
    rd_hi = 1'b1; #1; hi = rd_data;
    rd_hi = 1'b0; #1; lo = rd_data;
    chk("R7 upper half of -23", int'(hi), 5'b11111);
    chk("R7 lower half of -23", int'(lo), 5'b01001);
    read_ack("R6 held div leads", -23, 0);
  endtask

  task automatic t_tie;
    meas("R3 tie", N, 0, 0);
  endtask

  task automatic t_sat_pos;
    meas("R5 positive limit", 50, LIM, 1);
  endtask

  task automatic t_sat_neg;
    meas("R5 negative limit", N + 700, -LIM, 1);
  endtask

  task automatic t_coarse;      // R4: ticks every other cycle, 6 ticks in window
    @(negedge clk); #1;
    if (!ph) begin @(negedge clk); #1; end
    alt_mode = 1'b1;
    fine_sel = 1'b0;
    meas("R4 coarse count", 2*N + 12, -6, 0);
    alt_mode = 1'b0;
    fine_sel = 1'b1;
  endtask

  task automatic t_accum;       // R9: windows +5, -2, +4
    accum_en = 1'b1;
    pps_pulse(N - 5);
    pps_pulse(N + 7);
    chk("R9 no ready after first window", int'(rdy_n), 1);
    pps_pulse(N - 6);
    pps_pulse(2);
    repeat (4) @(negedge clk);
    chk("R9 rdy_n before last close", int'(rdy_n), 1);
    @(negedge clk);
    chk("R9 rdy_n at last close", int'(rdy_n), 0);
    read_ack("R9 accumulated", 7, 0);
    accum_en = 1'b0;
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ref_leads();
    t_div_leads_ignore();
    t_tie();
    t_sat_pos();
    t_sat_neg();
    t_coarse();
    t_accum();
    t_ref_leads();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule